// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns a parallel character of 5 to 8 bits into an asynchronous serial frame on one output line. A frame is a low start bit, the data bits with the least significant bit first, an optional parity bit, and a run of high stop bits that is one, one-and-a-half or two bit times long. Every bit lasts a fixed number of cycles of the transmit clock, 16 by default. The clock runs at 16 times the bit rate and is produced outside the block.

A holding register sits in front of the shift stage. A character can therefore be written while the previous one is still going out. It is handed over on the edge that ends the last stop clock, so the two frames follow each other with no idle time. Two flags report the state of the path. `hold_empty` says the holding register can take a new character. `shift_empty` says the line has finished every frame. The format inputs are captured once per character, at the moment of handover.

The shifter has five states. IDLE holds the line high. Handover moves it to START, which drives the line low for one bit time. START goes to DATA, which shifts out one bit per bit time. DATA goes to PARITY when parity is on and to STOP when it is off. PARITY goes to STOP after one bit time. STOP leaves by one of two transitions: it goes back to START when a character is waiting at its last clock, and to IDLE when none is.

Top module: `sertx_top`

## Requirements
- R1: `len_sel` picks the number of data bits sent: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R2: When `par_inh` is 1, no parity bit is sent. When it is 0, a parity bit follows the data bits. With `par_even`=1 that bit equals the XOR of the data bits sent (even parity). With `par_even`=0 it is the inverse of that XOR (odd parity).
- R3: The high stop period lasts 16 clocks when `stop_sel`=0. When `stop_sel`=1 it lasts 24 clocks for 5-bit characters and 32 clocks for the other lengths.
- R4: Each start, data and parity bit holds `txd` for exactly 16 clocks. The start bit is 0, data goes out least significant bit first, and the line is 1 when no frame is being sent.
- R5: `din` bits at and above the selected length have no effect on the data bits or on the parity bit.
- R6: `load_n` is sampled on the rising clock edge. While it is 0, `din` is written into the holding register. On the first edge that samples it as 1 after a 0, `hold_empty` goes to 0.
- R7: When the shifter is idle, the held character is transferred on the next edge after that. On that edge `shift_empty` goes to 0, `hold_empty` returns to 1 and the start bit begins.
- R8: A character that is loaded during a frame is transferred on the edge that ends the last stop clock. Its start bit follows with no idle clock, and `shift_empty` stays 0 across the join.
- R9: `shift_empty` goes to 1 only on the edge after the last stop clock of a frame, when no character is waiting.
- R10: `mrst`=1 asynchronously forces `shift_empty`=1, `hold_empty`=1 and `txd`=1, even in the middle of a frame.
- R11: `len_sel`, `par_inh`, `par_even` and `stop_sel` are captured at transfer. Changing them during a frame leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 16 cycles per bit |
| mrst | input | 1 | Master reset, active high, asynchronous |
| load_n | input | 1 | Holding-register write strobe, active low |
| din | input | 8 | Character to send, right-justified |
| len_sel | input | 2 | Character length code (5 to 8 bits) |
| par_inh | input | 1 | 1 = no parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel | input | 1 | 1 = long stop period (1.5 or 2 bits) |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register free |
| shift_empty | output | 1 | No frame in progress |

## Verification
The end of a frame's last stop clock and the transfer of a waiting character fall on the same edge. That edge has to do two jobs: move the shifter to START rather than to IDLE, and clear the waiting flag. To force this, the bench writes a second character and changes the format while the first frame is still running. It then checks every clock of both frames against waveforms computed from the two formats. The line must drop for the second start bit exactly one clock after the last stop clock, and `shift_empty` must never rise in between. The rest of the bench sweeps every combination of length, parity mode and stop setting and checks each clock of each frame.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
    localparam int CHAR_W  = 8;
    localparam int MIN_LEN = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_inh;
        logic       par_even;
        logic       stop_sel;
    } fmt_t;

    function automatic logic [CHAR_W-1:0] trim_char(input logic [CHAR_W-1:0] d,
                                                    input logic [1:0] ls);
        return d & (8'hFF >> (2'd3 - ls));
    endfunction

    function automatic logic [3:0] char_len(input logic [1:0] ls);
        return 4'(MIN_LEN) + {2'b00, ls};
    endfunction
endpackage

// File: rtl/sertx_holdbuf.sv
`timescale 1ns/1ps
module sertx_holdbuf
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              mrst,
    input  logic              load_n,
    input  logic [CHAR_W-1:0] din,
    input  logic              take,
    output logic [CHAR_W-1:0] held,
    output logic              pend
);
    logic load_q;
    logic rise;

    assign rise = load_n & ~load_q;

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            load_q <= 1'b1;
            pend   <= 1'b0;
            held   <= '0;
        end else begin
            load_q <= load_n;
            if (!load_n)
                held <= din;
            if (rise)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end

    // R6: a strobe release is followed by a pending character
    assert_pend_after_release_R6: assert property (@(posedge clk) disable iff (mrst)
        $rose(load_n) |=> pend);
endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              pend,
    input  logic [CHAR_W-1:0] held,
    input  fmt_t              fmt,
    output logic              take,
    output logic              txd,
    output logic              idle
);
    localparam int CW = $clog2(2 * OS);
    localparam logic [CW-1:0] BIT_LAST   = CW'(OS - 1);
    localparam logic [CW-1:0] HALF3_LAST = CW'((OS * 3) / 2 - 1);
    localparam logic [CW-1:0] TWO_LAST   = CW'(2 * OS - 1);

    tx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [CHAR_W-1:0] shreg;
    logic [3:0]        left;
    logic              par_bit;
    logic              has_par;
    logic [CW-1:0]     stop_last;
    logic              bit_end;
    logic              stop_end;
    logic [CHAR_W-1:0] nxt_char;

    assign bit_end  = (cnt == BIT_LAST);
    assign stop_end = (state == ST_STOP) && (cnt == stop_last);
    assign take     = pend && ((state == ST_IDLE) || stop_end);
    assign nxt_char = trim_char(held, fmt.len_sel);

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            left      <= '0;
            par_bit   <= 1'b0;
            has_par   <= 1'b0;
            stop_last <= BIT_LAST;
        end else if (take) begin
            state     <= ST_START;
            cnt       <= '0;
            shreg     <= nxt_char;
            left      <= char_len(fmt.len_sel);
            par_bit   <= (^nxt_char) ^ ~fmt.par_even;
            has_par   <= ~fmt.par_inh;
            stop_last <= !fmt.stop_sel ? BIT_LAST :
                         (fmt.len_sel == 2'd0) ? HALF3_LAST : TWO_LAST;
        end else begin
            unique case (state)
                ST_IDLE: cnt <= '0;
                ST_START: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) state <= ST_DATA;
                end
                ST_DATA: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        left  <= left - 1'b1;
                        if (left == 4'd1)
                            state <= has_par ? ST_PARITY : ST_STOP;
                    end
                end
                ST_PARITY: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) state <= ST_STOP;
                end
                ST_STOP: begin
                    cnt <= stop_end ? '0 : cnt + 1'b1;
                    if (stop_end) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle = (state == ST_IDLE);
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

    // R4: inside a bit the line does not move
    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (mrst)
        (state != ST_IDLE && cnt != '0) |-> $stable(txd));
    // R3: the stop counter never passes the captured stop length
    assert_stop_bound_R3: assert property (@(posedge clk) disable iff (mrst)
        (state == ST_STOP) |-> (cnt <= stop_last));
endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       mrst,
    input  logic       load_n,
    input  logic [7:0] din,
    input  logic [1:0] len_sel,
    input  logic       par_inh,
    input  logic       par_even,
    input  logic       stop_sel,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty
);
    logic              take;
    logic              pend;
    logic [CHAR_W-1:0] held;
    fmt_t              fmt;

    assign fmt = '{len_sel: len_sel, par_inh: par_inh, par_even: par_even,
                   stop_sel: stop_sel};

    sertx_holdbuf u_buf (
        .clk   (clk),
        .mrst  (mrst),
        .load_n(load_n),
        .din   (din),
        .take  (take),
        .held  (held),
        .pend  (pend)
    );

    sertx_framer #(.OS(OS)) u_frm (
        .clk  (clk),
        .mrst (mrst),
        .pend (pend),
        .held (held),
        .fmt  (fmt),
        .take (take),
        .txd  (txd),
        .idle (shift_empty)
    );

    assign hold_empty = ~pend;

    // R4: an empty shifter leaves the line at idle level
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (mrst)
        shift_empty |-> txd);
    // R9: the shifter empties only after a high stop clock
    assert_empty_after_stop_R9: assert property (@(posedge clk) disable iff (mrst)
        $rose(shift_empty) |-> ($past(txd) && txd));
    // R7: a frame always starts with a low line
    assert_start_low_R7: assert property (@(posedge clk) disable iff (mrst)
        $fell(shift_empty) |-> !txd);
endmodule

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
    logic       clk = 1'b0;
    logic       mrst = 1'b1;
    logic       load_n = 1'b1;
    logic [7:0] din = '0;
    logic [1:0] len_sel = '0;
    logic       par_inh = 1'b0;
    logic       par_even = 1'b0;
    logic       stop_sel = 1'b0;
    logic       txd, hold_empty, shift_empty;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sertx_top dut (
        .clk(clk), .mrst(mrst), .load_n(load_n), .din(din),
        .len_sel(len_sel), .par_inh(par_inh), .par_even(par_even),
        .stop_sel(stop_sel), .txd(txd), .hold_empty(hold_empty),
        .shift_empty(shift_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input int ls, input bit pi, input bit sb);
        int nb = 1 + 5 + ls + (pi ? 0 : 1);
        int st = !sb ? 16 : (ls == 0 ? 24 : 32);
        return 16 * nb + st;
    endfunction

    function automatic bit exp_line(input int ls, input bit pi, input bit ev,
                                    input bit sb, input logic [7:0] d, input int i);
        int len = 5 + ls;
        int idx = i / 16;
        logic [7:0] m = d & (8'hFF >> (3 - ls));
        if (sb) ;
        if (idx == 0) return 1'b0;
        if (idx <= len) return m[idx-1];
        if (!pi && idx == len + 1) return (^m) ^ ~ev;
        return 1'b1;
    endfunction

    // Called at the negedge of frame cycle 0; returns at the negedge after the frame.
    task automatic check_frame(input int ls, input bit pi, input bit ev, input bit sb,
                               input logic [7:0] d, input bit chained, input string req);
        int n = frame_len(ls, pi, sb);
        int bad = 0;
        int bad_i = -1;
        int act_v = 0;
        int exp_v = 0;
        for (int i = 0; i < n; i++) begin
            if (txd !== exp_line(ls, pi, ev, sb, d, i) || shift_empty !== 1'b0) begin
                if (bad == 0) begin
                    bad_i = i;
                    act_v = {shift_empty, txd};
                    exp_v = {1'b0, exp_line(ls, pi, ev, sb, d, i)};
                end
                bad++;
            end
            @(negedge clk);
        end
        chk(bad == 0, $sformatf("%s waveform ls=%0d pi=%0d ev=%0d sb=%0d d=%0h cyc=%0d",
            req, ls, pi, ev, sb, d, bad_i), act_v, exp_v);
        if (chained)
            chk(shift_empty === 1'b0 && txd === 1'b0, "R8 back-to-back join",
                {shift_empty, txd}, 2'b00);
        else
            chk(shift_empty === 1'b1 && txd === 1'b1, $sformatf("R3 R9 frame end len=%0d", n),
                {shift_empty, txd}, 2'b11);
    endtask

    task automatic load_char(input logic [7:0] d);
        @(negedge clk);
        din = d;
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic send_one(input int ls, input bit pi, input bit ev, input bit sb,
                            input logic [7:0] d, input string req);
        len_sel = 2'(ls); par_inh = pi; par_even = ev; stop_sel = sb;
        load_char(d);
        @(negedge clk);
        chk(hold_empty === 1'b0 && shift_empty === 1'b1, "R6 empty flag clears",
            {hold_empty, shift_empty}, 2'b01);
        @(negedge clk);
        chk(hold_empty === 1'b1 && shift_empty === 1'b0 && txd === 1'b0,
            "R7 transfer to shifter", {hold_empty, shift_empty, txd}, 3'b100);
        check_frame(ls, pi, ev, sb, d, 1'b0, req);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && hold_empty === 1'b1 && shift_empty === 1'b1,
            "R10 reset state", {txd, hold_empty, shift_empty}, 3'b111);
        mrst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4: sweep every format with two data patterns
        for (int ls = 0; ls < 4; ls++)
            for (int pm = 0; pm < 3; pm++)
                for (int sb = 0; sb < 2; sb++) begin
                    send_one(ls, pm == 2, pm == 1, sb[0], 8'(8'h5A ^ (ls * 37 + pm * 11 + sb)),
                             "R1 R2 R4");
                    send_one(ls, pm == 2, pm == 1, sb[0], 8'(8'hC3 + ls * 29 + pm * 7 + sb * 3),
                             "R1 R2 R4");
                end

        // R5: upper bits only, 5-bit even parity; all data and parity bits must be 0
        send_one(0, 1'b0, 1'b1, 1'b0, 8'hE0, "R5 upper bits ignored");
        // R5: full 5-bit data sweep with odd parity and 1.5 stop bits
        for (int v = 0; v < 32; v++)
            send_one(0, 1'b0, 1'b0, 1'b1, 8'(v | 8'hA0), "R5 R2 5-bit sweep");

        // R8 R11: second character and format change during the first frame
        len_sel = 2'd3; par_inh = 1'b0; par_even = 1'b1; stop_sel = 1'b1;
        load_char(8'h96);
        repeat (2) @(negedge clk);
        fork
            check_frame(3, 1'b0, 1'b1, 1'b1, 8'h96, 1'b1, "R11 first frame kept");
            begin
                repeat (20) @(negedge clk);
                len_sel = 2'd1; par_inh = 1'b0; par_even = 1'b0; stop_sel = 1'b0;
                load_char(8'hF5);
                @(negedge clk);
                chk(hold_empty === 1'b0, "R8 second char held", hold_empty, 0);
            end
        join
        chk(hold_empty === 1'b1, "R8 held char transferred", hold_empty, 1);
        check_frame(1, 1'b0, 1'b0, 1'b0, 8'hF5, 1'b0, "R8 R11 second frame");
        repeat (2) @(negedge clk);

        // R10: master reset during a frame
        len_sel = 2'd2; par_inh = 1'b1; stop_sel = 1'b0;
        load_char(8'h00);
        repeat (40) @(negedge clk);
        mrst = 1'b1;
        #1;
        chk(txd === 1'b1 && hold_empty === 1'b1 && shift_empty === 1'b1,
            "R10 mid-frame reset", {txd, hold_empty, shift_empty}, 3'b111);
        @(negedge clk);
        mrst = 1'b0;
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && shift_empty === 1'b1, "R10 stays idle after reset",
            {txd, shift_empty}, 2'b11);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule